// File: doc/BRIEF.md
# Synchronous PCM Serial Voice Port

This block is the serial side of a voice path. Samples are 14-bit two's-complement words. The port moves them between a converter core and a signal processor over a bit clock and a frame strobe, and both of those come from outside. The port never generates them. Everything runs on one fast system clock. The bit clock and the frame strobe are sampled on that clock, and the port acts on their edges.

On the receive side, the serial input is shifted in on falling bit-clock edges. The first falling edge at or after the frame strobe's rising edge carries the sign bit. Once fourteen bits have arrived, the word goes to a holding register together with a one-cycle valid strobe.

On the transmit side, the parallel word is captured at the frame strobe's rising edge. It is then presented MSB first, and each rising bit-clock edge advances to the next bit. The serial output is an open-drain line, modelled as two signals:
- a slot flag that is high during the 14-bit window;
- a pull-low flag that is high only when a zero is being sent.

Outside the window the line is released.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, pcm_out_slot, pcm_out_low and rx_valid are 0 and rx_data is 0.
- R2: rx_data is assembled MSB first from pcm_in at successive falling bclk edges. The first falling edge at or after a sync rising edge gives bit 13, the sign bit of the two's-complement word.
- R3: On the 14th falling edge of a frame, rx_data takes the new word and rx_valid is high for exactly one clk cycle. At all other times rx_data holds its value.
- R4: Falling edges after the 14th are ignored until the next sync rising edge. They cause no rx_valid and no change to rx_data.
- R5: tx_data is sampled only at a sync rising edge. Changes to it during a frame do not alter the bits being sent.
- R6: The transmit window opens at the sync rising edge with bit 13 of the sampled word. Each rising bclk edge then advances one bit toward bit 0, and the window closes at the 14th rising edge after launch.
- R7: A sync rising edge that coincides with a bclk rising edge launches bit 13 without also advancing it. Bit 13 is therefore shown for one full bclk period.
- R8: pcm_out_low is high only inside the window and only while the current bit is 0. A 1 bit leaves the line released.
- R9: While port_en is low, the window is closed, receive capture stops, and sync rising edges are ignored.
- R10: A sync rising edge in the middle of a frame restarts both directions from bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than bclk |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable; low releases the line and stops capture |
| bclk | input | 1 | External bit clock |
| sync | input | 1 | External frame strobe, phase-aligned to bclk |
| pcm_in | input | 1 | Serial receive data |
| tx_data | input | 14 | Parallel word to transmit |
| rx_data | output | 14 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when rx_data is updated |
| pcm_out_slot | output | 1 | High during the 14-bit transmit window |
| pcm_out_low | output | 1 | Pull the open-drain line low (current bit is 0) |

## Verification
The bench goes after the following corners:
- **Frame strobe aligned with a rising bit-clock edge.** A design that advanced there would drop the sign bit from the output.
- **Frame strobe rising in the middle of a high phase.** A design that waited for the next bclk edge would open the window late.
- **Extra bit-clock periods after a frame.** A capture that does not stop would raise a second strobe and corrupt the held word.
- **tx_data changed during a frame.** A design that read it live would send a mix of two words.
- **An all-ones word and a negative word.** These expose pull-low polarity errors and sign-bit placement.
- **A frame restarted after five bits.** This catches a counter that is not cleared.
- **A frame sent while disabled.** This catches a line that is driven or a word that is captured regardless of the enable.

// File: rtl/pcm_port_pkg.sv
// Package: shared types for the PCM serial voice port.
// Assumes: the edge flags are single-cycle pulses in the clk domain.
package pcm_port_pkg;
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/pcm_edge_detect.sv
// Module: pcm_edge_detect
// Samples bclk and sync on clk and emits one-cycle edge pulses. Each pulse
// appears in the clk cycle in which the new level is first seen.
// Assumes: bclk and sync are already synchronous to clk, and bclk is at most
// a quarter of the clk rate.
module pcm_edge_detect
    import pcm_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bclk,
    input  logic  sync,
    output edge_t bclk_edge,
    output logic  sync_rise
);
    logic bclk_q;
    logic sync_q;

    // Remember the previous level of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
            sync_q <= sync;
        end
    end

    // Compare the current level with the remembered one.
    always_comb begin
        bclk_edge.rise = bclk & ~bclk_q;
        bclk_edge.fall = ~bclk & bclk_q;
        sync_rise      = sync & ~sync_q;
    end
endmodule

// File: rtl/pcm_rx_deser.sv
// Module: pcm_rx_deser
// Shifts in W bits MSB first, one per falling bclk edge, after a frame start.
// The word goes to rx_data with a one-cycle rx_valid. Later bits are dropped
// until the next start.
// Assumes: start and shift are one-cycle pulses and may coincide.
module pcm_rx_deser #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] rx_data,
    output logic         rx_valid
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic [W-1:0]  shreg;
    logic          eff_active;
    logic [CW-1:0] eff_cnt;
    logic [W-1:0]  next_word;

    // A start in the same cycle as a shift counts as bit position zero.
    always_comb begin
        eff_active = start | active;
        eff_cnt    = start ? '0 : cnt;
        next_word  = start ? {{(W-1){1'b0}}, din} : {shreg[W-2:0], din};
    end

    // Track the frame, shift bits in and deliver the finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cnt      <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!en) begin
                active <= 1'b0;
            end else begin
                if (start) begin
                    active <= 1'b1;
                    cnt    <= '0;
                    shreg  <= '0;
                end
                if (shift && eff_active) begin
                    shreg <= next_word;
                    if (eff_cnt == LAST) begin
                        rx_data  <= next_word;
                        rx_valid <= 1'b1;
                        active   <= 1'b0;
                    end else begin
                        cnt <= eff_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pcm_tx_ser.sv
// Module: pcm_tx_ser
// Captures the word at a frame start and shows its MSB at once. Each rising
// bclk edge moves to the next bit, and the window closes after W bits.
// Outputs follow an open-drain model: slot plus pull-low.
// Assumes: a start that meets an advance in the same cycle only launches.
module pcm_tx_ser #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start,
    input  logic         advance,
    input  logic [W-1:0] tx_data,
    output logic         slot,
    output logic         pull_low
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          window;
    logic [CW-1:0] cnt;
    logic [W-1:0]  shreg;

    // Load on start, step on rising bclk edges, close after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
        end else if (!en) begin
            window <= 1'b0;
        end else if (start) begin
            window <= 1'b1;
            cnt    <= '0;
            shreg  <= tx_data;
        end else if (advance && window) begin
            if (cnt == LAST) begin
                window <= 1'b0;
            end else begin
                cnt   <= cnt + 1'b1;
                shreg <= {shreg[W-2:0], 1'b0};
            end
        end
    end

    // Pull the line low only for a zero bit inside the window.
    always_comb begin
        slot     = window;
        pull_low = window & ~shreg[W-1];
    end
endmodule

// File: rtl/pcm_voice_port.sv
// Module: pcm_voice_port (top)
// Frame-synchronised serial port for 14-bit two's-complement voice samples.
// Input bits are taken on falling bclk edges and output bits move on rising
// edges. The sync rising edge marks the MSB in both directions.
// Assumes: bclk and sync are synchronous to clk and phase-aligned to each other.
module pcm_voice_port #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         port_en,
    input  logic         bclk,
    input  logic         sync,
    input  logic         pcm_in,
    input  logic [W-1:0] tx_data,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic         pcm_out_slot,
    output logic         pcm_out_low
);
    import pcm_port_pkg::*;

    edge_t bclk_edge;
    logic  sync_rise;

    pcm_edge_detect i_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .sync      (sync),
        .bclk_edge (bclk_edge),
        .sync_rise (sync_rise)
    );

    pcm_rx_deser #(.W(W)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (port_en),
        .start    (sync_rise),
        .shift    (bclk_edge.fall),
        .din      (pcm_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    pcm_tx_ser #(.W(W)) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (port_en),
        .start    (sync_rise),
        .advance  (bclk_edge.rise),
        .tx_data  (tx_data),
        .slot     (pcm_out_slot),
        .pull_low (pcm_out_low)
    );
endmodule

// File: rtl/pcm_voice_port_checker.sv
// Module: pcm_voice_port_checker
// Protocol properties on the ports of pcm_voice_port, attached by bind.
// Assumes: sync is low while reset is held.
module pcm_voice_port_checker #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         port_en,
    input logic         sync,
    input logic [W-1:0] rx_data,
    input logic         rx_valid,
    input logic         pcm_out_slot,
    input logic         pcm_out_low
);
    assert_pull_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_out_low |-> pcm_out_slot);

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!pcm_out_slot && !rx_valid));

    assert_sync_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync) && port_en) |=> pcm_out_slot);
endmodule

bind pcm_voice_port pcm_voice_port_checker #(.W(W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_en      (port_en),
    .sync         (sync),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .pcm_out_slot (pcm_out_slot),
    .pcm_out_low  (pcm_out_low)
);

// File: tb/test_pcm_voice_port.sv
// Bench: a behavioural reference model (bit queue, integers) is compared with
// the DUT on every clock, and directed checks run after each scenario.
module test_pcm_voice_port;
    localparam int W = 14;
    localparam int HALF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         port_en = 1'b0;
    logic         bclk = 1'b0;
    logic         sync = 1'b0;
    logic         pcm_in = 1'b1;
    logic [W-1:0] tx_data = '0;
    logic [W-1:0] rx_data;
    logic         rx_valid;
    logic         pcm_out_slot;
    logic         pcm_out_low;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pcm_voice_port #(.W(W)) i_pcm_voice_port (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .bclk(bclk), .sync(sync),
        .pcm_in(pcm_in), .tx_data(tx_data), .rx_data(rx_data), .rx_valid(rx_valid),
        .pcm_out_slot(pcm_out_slot), .pcm_out_low(pcm_out_low)
    );

    // Reference model state.
    bit m_pb, m_ps;
    bit txq[$];
    int rx_left;
    int acc;
    int m_data;
    bit m_valid;

    always @(posedge clk) begin
        bit br, bf, sr;
        if (!rst_n) begin
            m_pb = 0; m_ps = 0; txq.delete(); rx_left = 0; acc = 0;
            m_data = 0; m_valid = 0;
        end else begin
            br = bclk && !m_pb;
            bf = !bclk && m_pb;
            sr = sync && !m_ps;
            m_pb = bclk;
            m_ps = sync;
            m_valid = 0;
            if (!port_en) begin
                txq.delete();
                rx_left = 0;
            end else begin
                if (sr) begin
                    txq.delete();
                    for (int k = W - 1; k >= 0; k--) txq.push_back(tx_data[k]);
                    rx_left = W;
                    acc = 0;
                end else if (br && txq.size() > 0) begin
                    void'(txq.pop_front());
                end
                if (bf && rx_left > 0) begin
                    acc = (acc << 1) | int'(pcm_in);
                    rx_left--;
                    if (rx_left == 0) begin
                        m_data = acc;
                        m_valid = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison and event counters.
    int slot_cycles = 0;
    int low_cycles = 0;
    int valid_cnt = 0;

    always @(negedge clk) begin
        bit e_slot, e_low;
        if (rst_n && !finished) begin
            e_slot = txq.size() > 0;
            e_low = e_slot && (txq[0] == 1'b0);
            chk(pcm_out_slot == e_slot, "R6 slot", int'(pcm_out_slot), int'(e_slot));
            chk(pcm_out_low == e_low, "R8 pull-low", int'(pcm_out_low), int'(e_low));
            chk(rx_valid == m_valid, "R3 rx_valid", int'(rx_valid), int'(m_valid));
            chk(int'(rx_data) == m_data, "R2 rx_data", int'(rx_data), m_data);
            if (pcm_out_slot) slot_cycles++;
            if (pcm_out_low) low_cycles++;
            if (rx_valid) valid_cnt++;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_counts();
        slot_cycles = 0; low_cycles = 0; valid_cnt = 0;
    endtask

    // One bclk period per bit. mis=1 raises sync mid-way through bit 0's high
    // phase. tx_data is inverted after bit 0 to test sampling.
    task automatic run_frame(input logic [W-1:0] rxw, input bit mis, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            bclk = 1'b1;
            if (i == 0 && !mis) sync = 1'b1;
            if (i == 1) sync = 1'b0;
            if (i == 0 && mis) begin
                wait_n(HALF / 2);
                sync = 1'b1;
                wait_n(HALF - HALF / 2);
            end else begin
                wait_n(HALF);
            end
            bclk = 1'b0;
            pcm_in = rxw[W-1-i];
            wait_n(HALF);
            if (i == 0) tx_data = ~tx_data;
        end
        sync = 1'b0;
    endtask

    task automatic idle_bits(input int n, input bit val);
        for (int i = 0; i < n; i++) begin
            bclk = 1'b1; wait_n(HALF);
            bclk = 1'b0; pcm_in = val; wait_n(HALF);
        end
    endtask

    initial begin
        logic [W-1:0] held;
        logic [W-1:0] txw;
        wait_n(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!pcm_out_slot && !pcm_out_low, "R1 line", int'({pcm_out_slot, pcm_out_low}), 0);
        chk(!rx_valid && rx_data == '0, "R1 rx", int'(rx_data), 0);
        port_en = 1'b1;
        idle_bits(2, 1'b1);

        // R7 aligned frame: window lasts exactly 14 bclk periods
        txw = 14'h1234; tx_data = txw; clear_counts();
        run_frame(14'h2A5C, 1'b0, W);
        idle_bits(2, 1'b1);
        chk(slot_cycles == W * 2 * HALF, "R7 window length", slot_cycles, W * 2 * HALF);
        chk(low_cycles == (W - $countones(txw)) * 2 * HALF, "R5 zeros of sampled word",
            low_cycles, (W - $countones(txw)) * 2 * HALF);
        chk(rx_data == 14'h2A5C, "R2 received word", int'(rx_data), 'h2A5C);
        chk(valid_cnt == 1, "R3 one strobe", valid_cnt, 1);

        // R4 extra bits after the 14th are ignored
        clear_counts();
        idle_bits(5, 1'b0);
        chk(rx_data == 14'h2A5C, "R4 word held", int'(rx_data), 'h2A5C);
        chk(valid_cnt == 0, "R4 no strobe", valid_cnt, 0);

        // R8 all ones never pulls low; negative word keeps its sign bit
        tx_data = 14'h3FFF; clear_counts();
        run_frame(14'h2001, 1'b0, W);
        idle_bits(2, 1'b1);
        chk(low_cycles == 0, "R8 ones release", low_cycles, 0);
        chk(rx_data == 14'h2001, "R2 negative word", int'(rx_data), 'h2001);

        // R6 misaligned sync launches at its own edge
        tx_data = 14'h0000; clear_counts();
        run_frame(14'h15A3, 1'b1, W);
        idle_bits(2, 1'b1);
        chk(slot_cycles == HALF - HALF / 2 + 13 * 2 * HALF + HALF,
            "R6 misaligned window", slot_cycles, HALF - HALF / 2 + 13 * 2 * HALF + HALF);
        chk(rx_data == 14'h15A3, "R2 misaligned word", int'(rx_data), 'h15A3);

        // R10 restart after five bits
        tx_data = 14'h0F0F; clear_counts();
        run_frame(14'h3FFF, 1'b0, 5);
        run_frame(14'h0C35, 1'b0, W);
        idle_bits(2, 1'b1);
        chk(rx_data == 14'h0C35, "R10 restarted word", int'(rx_data), 'h0C35);
        chk(valid_cnt == 1, "R10 single strobe", valid_cnt, 1);

        // R9 disabled port ignores a frame
        held = rx_data;
        port_en = 1'b0; clear_counts();
        run_frame(14'h1111, 1'b0, W);
        idle_bits(2, 1'b0);
        chk(slot_cycles == 0, "R9 line released", slot_cycles, 0);
        chk(valid_cnt == 0 && rx_data == held, "R9 no capture", int'(rx_data), int'(held));

        // Re-enable: the port works again on the next frame
        port_en = 1'b1; tx_data = 14'h2AAA;
        run_frame(14'h0777, 1'b0, W);
        idle_bits(2, 1'b1);
        chk(rx_data == 14'h0777, "R9 resume", int'(rx_data), 'h0777);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule